// File: doc/BRIEF.md
# First-Word-Fall-Through Read Output Stage

This block is the read side of a FIFO that works in first-word-fall-through fashion. It pulls words out of the storage read port on its own, ahead of any request. The oldest word is therefore already on the data outputs when the consumer looks. An active-low ready output tells the consumer that the word on the outputs is valid and not yet taken. A read is taken only on a rising clock edge where the read enable is low and the ready output is low.

The storage is assumed to have a registered read port. A strobe on `mem_rd` pops one word at the clock edge, and that word appears on `mem_rdata` after the edge and stays there until the next strobe. The word then moves through two holding registers to the output register. This gives a fixed fill latency of three read-clock edges after the storage stops reporting empty. Once those registers are full, one word can be delivered on every cycle. When the final word is taken, the ready output goes high and the outputs keep showing that consumed word.

Top module: `fwft_out_stage`

## Requirements
- R1: A synchronous active-high reset drives `out_rdy_n` high and `dout` to zero. No `mem_rd` strobe is issued while reset is high, even if the storage is not empty.
- R2: Words appear on `dout` in the order the storage holds them. Each word is delivered exactly once.
- R3: `out_rdy_n` is low whenever `dout` holds an untaken word, including just after the last stored word has moved onto the outputs. It rises only on a clock edge where `rd_en_n` is low (active-low read enable) and `out_rdy_n` was low.
- R4: After the final word is taken, `dout` keeps showing that word while `out_rdy_n` stays high.
- R5: A low `rd_en_n` while `out_rdy_n` is high has no effect: `dout` does not change and no word is consumed.
- R6: When a word enters an empty storage, `out_rdy_n` stays high after the first and second read-clock edges following the edge where `mem_empty` falls. It goes low after the third.
- R7: With the holding registers full, a read on every cycle delivers one new word per cycle with `out_rdy_n` held low throughout.
- R8: `mem_rd` is raised only when `mem_empty` is low and the prefetch slot is free or being emptied in the same cycle. At most three fetched words are held in the stage at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en_n | input | 1 | Read enable, active low |
| mem_empty | input | 1 | Storage empty status, high when no word is stored |
| mem_rdata | input | DATA_W | Registered storage read data, valid after a strobe edge |
| mem_rd | output | 1 | Storage read strobe, pops one word at the edge |
| dout | output | DATA_W | Word presented to the consumer |
| out_rdy_n | output | 1 | Output ready, low while `dout` holds an untaken word |

## Verification
The in-design properties check, on every cycle, that the ready output rises only after a true read, that `dout` stays frozen while the ready output is high, that a ready fall traces back to a strobe exactly three edges earlier, and that a read with a staged word behind it moves that word out in the next cycle. The bench scenarios cover what the properties cannot. The exact edge at which the first word falls through is checked against a storage model. Ordering across irregular write and read patterns is checked by the scoreboard, and an eight-read burst confirms full rate. The scenarios also confirm that reset blocks strobes against a non-empty storage and that nothing is popped from an empty storage or over-fetched.

// File: rtl/fwft_pkg.sv
`timescale 1ns/1ps
package fwft_pkg;
  // Default data width of the read path.
  parameter int unsigned FWFT_DEFAULT_W = 18;
  // Holding registers between the storage read register and the consumer
  // (one middle stage plus the output register).
  parameter int unsigned FWFT_HOLD_STAGES = 2;
  // Edges from storage non-empty to ready: one fetch edge plus each stage.
  parameter int unsigned FWFT_FILL_EDGES = FWFT_HOLD_STAGES + 1;
endpackage

// File: rtl/fwft_fetch_ctl.sv
`timescale 1ns/1ps
module fwft_fetch_ctl (
  input  logic clk,
  input  logic rst,
  input  logic mem_empty,
  input  logic slot_drain,
  output logic mem_rd,
  output logic pend
);
  logic pend_q;

  // Pop a word when storage has one and the storage read register is free
  // or its word moves into the first holding stage this cycle.
  assign mem_rd = ~rst & ~mem_empty & (~pend_q | slot_drain);
  assign pend   = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (mem_rd) begin
      pend_q <= 1'b1;
    end else if (slot_drain) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fwft_stage_reg.sv
`timescale 1ns/1ps
module fwft_stage_reg #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              drain,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end

  // Data is never cleared on drain: a consumed word stays visible.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end
  end
endmodule

// File: rtl/fwft_out_stage.sv
`timescale 1ns/1ps
module fwft_out_stage
  import fwft_pkg::*;
#(
  parameter int unsigned DATA_W = FWFT_DEFAULT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_n,
  input  logic              mem_empty,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic [DATA_W-1:0] dout,
  output logic              out_rdy_n
);
  localparam int unsigned NS   = FWFT_HOLD_STAGES;
  localparam int unsigned LAST = NS - 1;
  localparam int unsigned LAT  = FWFT_FILL_EDGES;

  logic [NS-1:0]     stg_v;
  logic [NS-1:0]     stg_load;
  logic [NS-1:0]     stg_fill;
  logic [NS-1:0]     stg_drain;
  logic [DATA_W-1:0] stg_din [NS];
  logic [DATA_W-1:0] stg_q   [NS];
  logic              pend;
  logic              take;

  // A true read: output register holds a word and the enable is low.
  assign take = stg_v[LAST] & ~rd_en_n;

  fwft_fetch_ctl u_fetch (
    .clk        (clk),
    .rst        (rst),
    .mem_empty  (mem_empty),
    .slot_drain (stg_load[0]),
    .mem_rd     (mem_rd),
    .pend       (pend)
  );

  for (genvar i = 0; i < NS; i++) begin : g_stg
    if (i == 0) begin : g_head
      assign stg_fill[i] = pend;
      assign stg_din[i]  = mem_rdata;
    end else begin : g_body
      assign stg_fill[i] = stg_v[i-1];
      assign stg_din[i]  = stg_q[i-1];
    end

    if (i == LAST) begin : g_tail
      assign stg_drain[i] = take;
    end else begin : g_link
      assign stg_drain[i] = stg_load[i+1];
    end

    assign stg_load[i] = stg_fill[i] & (~stg_v[i] | stg_drain[i]);

    fwft_stage_reg #(.DATA_W(DATA_W)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .load  (stg_load[i]),
      .drain (stg_drain[i]),
      .din   (stg_din[i]),
      .q     (stg_q[i]),
      .valid (stg_v[i])
    );
  end

  assign dout      = stg_q[LAST];
  assign out_rdy_n = ~stg_v[LAST];

  // Ready may only rise after an edge that saw a true read.
  AST_RDY_RISE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(out_rdy_n) |-> $past(~rd_en_n)); // R3

  // While nothing untaken is shown, the outputs stay frozen.
  AST_STALE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_rdy_n && $past(out_rdy_n)) |-> $stable(dout)); // R4

  // A fall of ready traces back to a storage strobe exactly LAT edges ago.
  AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $fell(out_rdy_n) |-> $past(mem_rd, LAT)); // R6

  // A read with a staged word behind it presents that word next cycle
  // (stage 0 feeds the output register with the default two stages).
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (!out_rdy_n && !rd_en_n && stg_v[0]) |=> (!out_rdy_n && dout == $past(stg_q[0]))); // R7
endmodule

// File: tb/sim_fwft_out_stage.sv
`timescale 1ns/1ps
module sim_fwft_out_stage;
  localparam int W = 18;

  typedef enum logic [1:0] {RD_OFF, RD_ON, RD_RAND} rd_mode_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rd_en_n = 1'b1;
  logic         mem_empty = 1'b1;
  logic [W-1:0] mem_rdata = '0;
  logic         mem_rd;
  logic [W-1:0] dout;
  logic         out_rdy_n;

  always #5 clk = ~clk;

  fwft_out_stage #(.DATA_W(W)) u0 (
    .clk       (clk),
    .rst       (rst),
    .rd_en_n   (rd_en_n),
    .mem_empty (mem_empty),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .dout      (dout),
    .out_rdy_n (out_rdy_n)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [W-1:0] store_q[$];
  logic [W-1:0] exp_q[$];
  logic         wr_req = 1'b0;
  logic [W-1:0] wr_data = '0;
  int popped = 0, consumed = 0;
  int pop_bad = 0, strobe_bad = 0, over_bad = 0;
  rd_mode_t rd_mode = RD_OFF;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Storage model: registered read port, pop on strobe, push on write.
  always @(posedge clk) begin
    if (mem_rd) begin
      if (store_q.size() == 0) pop_bad++;
      else begin
        mem_rdata <= store_q.pop_front();
        popped++;
      end
    end
    if (wr_req) store_q.push_back(wr_data);
    mem_empty <= (store_q.size() == 0);
  end

  // Read-enable driver.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rd_mode)
      RD_OFF:  rd_en_n = 1'b1;
      RD_ON:   rd_en_n = 1'b0;
      default: rd_en_n = lfsr[0] & lfsr[5];
    endcase
  end

  // Monitor: pops the scoreboard on each true read, sampled mid-cycle.
  always begin
    @(negedge clk);
    #3;
    if (!rst) begin
      if (mem_rd && mem_empty) strobe_bad++;      // R8
      if (popped - consumed > 3) over_bad++;      // R8
      if (!out_rdy_n && !rd_en_n) begin
        consumed++;
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected word", dout, 0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(dout == e, "R2 order", dout, e);
        end
      end
    end
  end

  task automatic put(input logic [W-1:0] d);
    @(negedge clk);
    wr_req  = 1'b1;
    wr_data = d;
    exp_q.push_back(d);
  endtask

  task automatic idle_w();
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic sample();
    @(negedge clk);
    #3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int c0;
    // Reset with a word already in storage: no strobe allowed.
    @(negedge clk);
    put(18'h00155);
    idle_w();
    sample();
    chk(out_rdy_n == 1'b1, "R1 ready in reset", out_rdy_n, 1);
    chk(dout == '0, "R1 dout in reset", dout, 0);
    chk(mem_rd == 1'b0, "R1 strobe in reset", mem_rd, 0);
    @(negedge clk);
    rst = 1'b0;

    // Word falls through; storage now empty, ready stays low.
    repeat (5) @(negedge clk);
    #3;
    chk(out_rdy_n == 1'b0 && mem_empty, "R3 last word ready", out_rdy_n, 0);
    chk(dout == 18'h00155, "R2 fall-through word", dout, 18'h00155);

    // Read the last word, keep requesting: ignored, stale word held.
    rd_mode = RD_ON;
    repeat (4) @(negedge clk);
    #3;
    chk(out_rdy_n == 1'b1, "R3 ready after last read", out_rdy_n, 1);
    chk(dout == 18'h00155, "R4 stale word kept", dout, 18'h00155);
    chk(consumed == 1, "R5 reads while not ready ignored", consumed, 1);
    rd_mode = RD_OFF;

    // Fill latency into an empty storage.
    sample();
    put(18'h02A5A);
    @(negedge clk);            // after the edge that stores the word
    wr_req = 1'b0;
    #3;
    chk(out_rdy_n == 1'b1, "R6 edge 0", out_rdy_n, 1);
    sample();
    chk(out_rdy_n == 1'b1, "R6 edge 1", out_rdy_n, 1);
    sample();
    chk(out_rdy_n == 1'b1, "R6 edge 2", out_rdy_n, 1);
    sample();
    chk(out_rdy_n == 1'b0, "R6 edge 3", out_rdy_n, 0);
    chk(dout == 18'h02A5A, "R6 word after fill", dout, 18'h02A5A);
    rd_mode = RD_ON;
    repeat (3) @(negedge clk);
    #3;
    rd_mode = RD_OFF;
    repeat (2) @(negedge clk);

    // Full-rate burst of eight reads.
    for (int i = 0; i < 8; i++) put(18'h01000 + W'(i));
    idle_w();
    repeat (12) @(negedge clk);
    #3;
    c0 = consumed;
    chk(out_rdy_n == 1'b0, "R7 ready before burst", out_rdy_n, 0);
    rd_mode = RD_ON;
    repeat (8) @(negedge clk);
    #1;
    rd_mode = RD_OFF;
    sample();
    chk(consumed - c0 == 8, "R7 one word per cycle", consumed - c0, 8);
    chk(out_rdy_n == 1'b1, "R3 ready after burst", out_rdy_n, 1);
    chk(dout == 18'h01007, "R4 last burst word kept", dout, 18'h01007);

    // Irregular writes against random reads.
    rd_mode = RD_RAND;
    for (int i = 0; i < 48; i++) begin
      put(18'h20000 | W'(i * 37));
      if (i % 3 == 0) idle_w();
    end
    idle_w();
    #1;
    rd_mode = RD_ON;
    repeat (30) @(negedge clk);
    #3;
    rd_mode = RD_OFF;
    chk(exp_q.size() == 0, "R2 all words delivered", exp_q.size(), 0);
    chk(out_rdy_n == 1'b1, "R3 drained", out_rdy_n, 1);
    chk(pop_bad == 0, "R8 pop from empty storage", pop_bad, 0);
    chk(strobe_bad == 0, "R8 strobe while empty", strobe_bad, 0);
    chk(over_bad == 0, "R8 at most three held", over_bad, 0);
    finish_run();
  end
endmodule